// File: doc/BRIEF.md
# Pipelined Alpha Blend Datapath

This block mixes two unsigned pixel samples, A and B, under a blend factor F, giving A·F + B·(1−F) in fixed point. F is one bit wider than a sample, and the value 2^W means 1.0. The complement G is formed as 2^W − F. Each of the two lanes has a multiplier and a 2:1 select. The select is driven by the top bit of the lane's factor, and it picks either the upper half of the product or the sample itself, unscaled. The two lane results meet in an adder that clamps at full scale.

The multiplier has a parameterised number of internal register stages, from 0 to 2. The bypass operand and the select bit are delayed by the same number of registers, so all three mux inputs of a lane stay aligned. The inputs and the output are registered. Samples enter and leave on valid/ready handshakes. A transfer takes place on a rising edge where valid and ready are both high. The whole pipeline advances together and holds still while the output is valid but not taken. `in_ready` is therefore high exactly when `out_valid` is low or `out_ready` is high. Empty slots pass through as empty slots, so the pipeline does not close gaps between samples.

Top module: `alpha_blend`

## Requirements
- R1: When F[W] is 0, the A lane term is (A × F[W−1:0]) >> W, with the low W bits of the product dropped.
- R2: When F[W] is 1 (any F ≥ 2^W), the A lane term is A, unscaled. For F = 256 with W = 8, the output equals A.
- R3: G = (2^W − F) mod 2^(W+1). When G[W] is 0, the B lane term is (B × G[W−1:0]) >> W. When G[W] is 1 it is B unscaled, so F = 0 gives an output equal to B.
- R4: `out_pix` is the sum of the two lane terms, clamped to 2^W − 1 when the sum exceeds it.
- R5: With `out_ready` held high, a sample accepted at one rising edge is presented with `out_valid` high right after the (1 + MULT_STAGES)th following edge. The path holds 2 + MULT_STAGES registers.
- R6: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and on the next cycle `out_valid` stays high with `out_pix` unchanged.
- R7: `in_ready` is high in every cycle where `out_valid` is low or `out_ready` is high.
- R8: After reset, `out_valid` is 0, `out_pix` is 0 and `in_ready` is 1.
- R9: Every accepted sample produces exactly one output transfer, in order of acceptance. No output appears for a cycle where nothing was accepted. At most 2 + MULT_STAGES samples are in flight at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_a | input | W | Sample A |
| in_b | input | W | Sample B |
| in_f | input | W+1 | Blend factor, 2^W is 1.0 |
| out_valid | output | 1 | Blended result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_pix | output | W | Saturated blended result |

## Verification
The bench builds the block with W = 8 and MULT_STAGES = 2. This is the deepest setting: it brings in the split partial-product multiplier and two levels of balancing registers on the select and bypass paths. In that setting a mismatch between the delay of the select bit and the delay of the product shows up as wrong pixels. Corner factors (0, 128, 256, above 256, 511) are driven back to back with exact latency checks. After that comes a long run in which random consumer stalls exercise the hold and back-pressure rules.

// File: rtl/blend_pkg.sv
package blend_pkg;
  localparam int unsigned MULT_STAGES_MAX = 2;

  typedef enum logic {
    SEL_PRODUCT = 1'b0,
    SEL_BYPASS  = 1'b1
  } lane_sel_e;
endpackage

// File: rtl/blend_delay.sv
module blend_delay #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (DEPTH == 0) begin : g_wire
      logic unused_ctl;
      assign unused_ctl = &{1'b0, clk, rst_n, en};
      assign q = d;
    end else begin : g_regs
      logic [W-1:0] stage_q [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            stage_q[i] <= '0;
          end else if (en) begin
            if (i == 0) stage_q[i] <= d;
            else        stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
          end
        end
      end
      assign q = stage_q[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/blend_mult.sv
module blend_mult #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  localparam int unsigned LO_W = W / 2;
  localparam int unsigned HI_W = W - LO_W;

  generate
    if (STAGES == 0) begin : g_comb
      logic unused_ctl;
      assign unused_ctl = &{1'b0, clk, rst_n, en};
      assign p = {{W{1'b0}}, x} * {{W{1'b0}}, y};
    end else if (STAGES == 1) begin : g_one
      logic [2*W-1:0] p_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  p_q <= '0;
        else if (en) p_q <= {{W{1'b0}}, x} * {{W{1'b0}}, y};
      end
      assign p = p_q;
    end else begin : g_split
      logic [W+LO_W-1:0] pp_lo_q;
      logic [W+HI_W-1:0] pp_hi_q;
      logic [2*W-1:0]    sum_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pp_lo_q <= '0;
          pp_hi_q <= '0;
          sum_q   <= '0;
        end else if (en) begin
          pp_lo_q <= {{LO_W{1'b0}}, x} * {{W{1'b0}}, y[LO_W-1:0]};
          pp_hi_q <= {{HI_W{1'b0}}, x} * {{W{1'b0}}, y[W-1:LO_W]};
          sum_q   <= {pp_hi_q, {LO_W{1'b0}}} + {{HI_W{1'b0}}, pp_lo_q};
        end
      end
      blend_delay #(.W(2*W), .DEPTH(STAGES-2)) u_tail (
        .clk(clk), .rst_n(rst_n), .en(en), .d(sum_q), .q(p)
      );
    end
  endgenerate
endmodule

// File: rtl/blend_lane.sv
module blend_lane
  import blend_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] opnd,
  input  logic [W:0]   fac,
  output logic [W-1:0] term
);
  logic [2*W-1:0] prod;
  logic [W:0]     side_d;
  lane_sel_e      sel_d;
  logic [W-1:0]   opnd_d;
  logic [W-1:0]   unused_lo;

  blend_mult #(.W(W), .STAGES(STAGES)) u_mult (
    .clk(clk), .rst_n(rst_n), .en(en),
    .x(opnd), .y(fac[W-1:0]), .p(prod)
  );

  // select bit and bypass operand wait as long as the product does
  blend_delay #(.W(W+1), .DEPTH(STAGES)) u_side (
    .clk(clk), .rst_n(rst_n), .en(en),
    .d({fac[W], opnd}), .q(side_d)
  );

  assign sel_d     = lane_sel_e'(side_d[W]);
  assign opnd_d    = side_d[W-1:0];
  assign unused_lo = prod[W-1:0];

  always_comb begin
    case (sel_d)
      SEL_BYPASS: term = opnd_d;
      default:    term = prod[2*W-1:W];
    endcase
  end
endmodule

// File: rtl/alpha_blend.sv
module alpha_blend #(
  parameter int unsigned W           = 8,
  parameter int unsigned MULT_STAGES = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic [W:0]   in_f,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_pix
);
  localparam logic [W:0] UNITY = {1'b1, {W{1'b0}}};

  logic         adv;
  logic         r_v;
  logic [W-1:0] r_a, r_b;
  logic [W:0]   r_f, r_g;
  logic [W-1:0] term_a, term_b;
  logic         v_d;
  logic [W:0]   sum;
  logic [W-1:0] sat;

  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_v <= 1'b0;
      r_a <= '0;
      r_b <= '0;
      r_f <= '0;
    end else if (adv) begin
      r_v <= in_valid;
      r_a <= in_a;
      r_b <= in_b;
      r_f <= in_f;
    end
  end

  assign r_g = UNITY - r_f;

  blend_lane #(.W(W), .STAGES(MULT_STAGES)) u_lane_a (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .opnd(r_a), .fac(r_f), .term(term_a)
  );

  blend_lane #(.W(W), .STAGES(MULT_STAGES)) u_lane_b (
    .clk(clk), .rst_n(rst_n), .en(adv),
    .opnd(r_b), .fac(r_g), .term(term_b)
  );

  blend_delay #(.W(1), .DEPTH(MULT_STAGES)) u_vld (
    .clk(clk), .rst_n(rst_n), .en(adv), .d(r_v), .q(v_d)
  );

  assign sum = {1'b0, term_a} + {1'b0, term_b};
  assign sat = sum[W] ? {W{1'b1}} : sum[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else if (adv) begin
      out_valid <= v_d;
      out_pix   <= sat;
    end
  end
endmodule

// File: rtl/blend_chk.sv
module blend_chk #(
  parameter int unsigned W   = 8,
  parameter int unsigned LAT = 3
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_pix
);
  logic [7:0] inflight;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 8'(in_valid && in_ready) - 8'(out_valid && out_ready);
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));          // R6
  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);                                 // R6
  AST_EMPTY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);                                                 // R7
  AST_INFLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 8'(LAT));                                                     // R9
  AST_NO_PHANTOM_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (inflight == 8'd0) |-> !out_valid);                                       // R9
endmodule

bind alpha_blend blend_chk #(.W(W), .LAT(2 + MULT_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
);

// File: tb/sim_alpha_blend.sv
module sim_alpha_blend;
  localparam int MS  = 2;
  localparam int LAT = 2 + MS;

  typedef struct {
    logic [7:0] pix;
    int         cyc;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_a = '0, in_b = '0;
  logic [8:0] in_f = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_pix;

  int    checks = 0, errors = 0;
  int    cyc = 0;
  int    sent = 0, got = 0;
  bit    lat_mode = 1'b1, stall_mode = 1'b0, done = 1'b0;
  item_t sb[$];
  logic [31:0] rnd = 32'h1234_5678, rnd_r = 32'h9e37_79b9;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  alpha_blend #(.W(8), .MULT_STAGES(MS)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_f(in_f),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model(input logic [7:0] a, input logic [7:0] b, input logic [8:0] f);
    logic [8:0] g;
    int pa, pb, s;
    g  = 9'(256 - int'(f));
    pa = f[8] ? int'(a) : (int'(a) * int'(f[7:0])) / 256;
    pb = g[8] ? int'(b) : (int'(b) * int'(g[7:0])) / 256;
    s  = pa + pb;
    return (s > 255) ? 8'd255 : 8'(s);
  endfunction

  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    return t ^ (t << 5);
  endfunction

  // driver: called at a negedge, returns at a negedge after acceptance
  task automatic send(input logic [7:0] a, input logic [7:0] b, input logic [8:0] f);
    item_t it;
    in_a = a; in_b = b; in_f = f; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    it.pix = model(a, b, f);
    it.cyc = cyc;
    sb.push_back(it);
    sent++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // consumer ready pattern, changed well away from both edges
  always @(posedge clk) begin
    #2;
    rnd_r = step(rnd_r);
    out_ready = stall_mode ? (rnd_r[3:0] > 4'd5) : 1'b1;
  end

  // monitor / scoreboard
  bit         hold_pend = 1'b0;
  logic [7:0] held;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (hold_pend) begin
        chk(out_valid === 1'b1, "R6 valid held", int'(out_valid), 1);
        chk(out_pix === held, "R6 pixel held", int'(out_pix), int'(held));
      end
      hold_pend = 1'b0;
      if (out_valid && !out_ready) begin
        chk(in_ready === 1'b0, "R6 in_ready low on stall", int'(in_ready), 0);
        hold_pend = 1'b1;
        held = out_pix;
      end else begin
        chk(in_ready === 1'b1, "R7 in_ready high", int'(in_ready), 1);
      end
      if (out_valid && out_ready) begin
        got++;
        if (sb.size() == 0) begin
          chk(1'b0, "R9 output with nothing accepted", int'(out_pix), -1);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(out_pix === it.pix, "R4 R1 R3 blended pixel", int'(out_pix), int'(it.pix));
          if (lat_mode)
            chk(cyc - it.cyc == LAT, "R5 latency", cyc - it.cyc, LAT);
        end
      end
    end
  end

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R9 watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk(out_valid === 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
    chk(out_pix === 8'd0, "R8 out_pix in reset", int'(out_pix), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 out_valid after reset", int'(out_valid), 0);
    chk(in_ready === 1'b1, "R8 in_ready after reset", int'(in_ready), 1);

    // corner factors back to back, no stalls
    send(8'd200, 8'd17, 9'd256);   // R2: out = A
    send(8'd45, 8'd99, 9'd0);      // R3: out = B
    send(8'd255, 8'd255, 9'd128);  // R1 R3: 127 + 127 = 254
    send(8'd200, 8'd200, 9'd300);  // R2 R3 R4: both bypass, clamps to 255
    send(8'd180, 8'd240, 9'd511);  // R4: G = 257, bypass B, clamps
    send(8'd255, 8'd255, 9'd1);    // R1: 0 + 254
    send(8'd255, 8'd255, 9'd255);  // R1: 254 + 0
    send(8'd10, 8'd250, 9'd64);    // R1 R3: 2 + 187
    for (int i = 0; i < 60; i++) begin
      rnd = step(rnd);
      send(rnd[7:0], rnd[15:8], rnd[24:16]);
    end
    // sparse input: bubbles must not produce outputs (R9)
    for (int i = 0; i < 20; i++) begin
      rnd = step(rnd);
      send(rnd[7:0], rnd[15:8], {1'b0, rnd[23:16]});
      idle(int'(rnd[27:26]));
    end
    idle(LAT + 4);
    chk(sb.size() == 0, "R9 phase one drained", sb.size(), 0);

    // random consumer stalls
    lat_mode = 1'b0;
    stall_mode = 1'b1;
    for (int i = 0; i < 300; i++) begin
      rnd = step(rnd);
      send(rnd[7:0], rnd[15:8], (rnd[31:30] == 2'b00) ? 9'(rnd[20] ? 256 : 0) : rnd[24:16]);
      if (rnd[29:28] == 2'b11) idle(1);
    end
    stall_mode = 1'b0;
    idle(LAT + 20);
    chk(sb.size() == 0, "R9 all accepted samples delivered", sb.size(), 0);
    chk(got == sent, "R9 one output per input", got, sent);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule